// File: doc/BRIEF.md
# Arbitration Event Statistics Gatherer

This block watches the grant stream of a memory arbiter and counts chosen arbitration events over a window that software opens and closes. Each cycle, the arbiter presents one observation: whether a grant happened, which client won, the transfer direction, and a set of side flags. The side flags are three priority-request signals (high-priority, timeout, bandwidth), page-miss, auto-precharge, and two bank-arbitration flags. Two independent gather counters each apply their own control word to that stream. A control word picks an event class, optionally restricts counting to one client ID, and can qualify the count on the level of one of the three priority signals. A shared clock counter measures the length of the window. Software divides the event counts by the clock count later; this block does no such division.

A command register drives a small state machine. The state machine has four states:
- `ST_IDLE`: zeroed and not counting.
- `ST_RUN`: counting.
- `ST_HOLD`: disabled, with the values kept.
- `ST_SAT`: the clock counter has reached its programmable limit, and all three counters are frozen so they describe the same window.

The transitions are:
- A reset or clear command moves any state to `ST_IDLE`.
- A disable command moves any state to `ST_HOLD`.
- An enable command moves any state to `ST_RUN`, or to `ST_SAT` if the counter is already at the limit.
- `ST_RUN` moves to `ST_SAT` when the clock count reaches the limit.

The register bus is a single-cycle write port with a combinational read port, at these word addresses:

| Address | Register |
|---|---|
| 0 | command |
| 1 | limit |
| 2 | control word of gather 0 |
| 3 | control word of gather 1 |
| 4 | clock count |
| 5 | count of gather 0 |
| 6 | count of gather 1 |

Top module: `arb_stat_gatherer`

## Requirements
- R1: After a clear or reset command, the clock counter reads 0. It then increases by exactly one on every clock edge at which the state is `ST_RUN`, including the edge that writes a disable command.
- R2: The event select field is bits 23:16 of a control word.
  - Value 0 counts every valid grant.
  - Value 1 counts valid read grants (write flag 0).
  - Value 2 counts valid write grants.
  - Each gather counter grows by at most one per cycle.
- R3: Bit 26 enables the client filter, and bits 13:8 hold the client ID. When bit 26 is set, only grants whose winner equals that ID are counted. When it is clear, grants from every client are counted.
- R4: Bits 25:24 pick the priority signal: 0 high-priority, 1 timeout, 2 bandwidth. Bits 29:28 set the priority filter mode:
  - 0 ignores the signal.
  - 1 counts only when the signal is low.
  - 2 counts only when it is high.
  - 3 counts nothing.
- R5: Event select 4 counts grants whose winner equals the previous valid grant's winner. N back-to-back grants to one client count N-1. Cycles without a grant do not break the chain.
- R6: Event select 3 counts grants whose direction differs from that of the previous valid grant.
- R7: Event selects for the side flags:
  - 5 counts grants with the bank-AA flag.
  - 6 counts grants with the bank-BB flag.
  - 7 counts grants with page-miss.
  - 8 counts grants with auto-precharge.

  A flag counts only together with a valid grant. Select values of 9 and above count nothing.
- R8: The disable command (value 2 in command bits 9:8) holds all three counts, and grants seen while it holds are ignored. A later enable command (value 3) resumes counting from the held values.
- R9: The reset command (0) and the clear command (1) zero all three counts and forget the previous-winner and previous-direction history.
- R10: The clock counter stops at the limit register, and both event counters stop on the same edge. The limit resets to all ones.
- R11: After reset, every register reads 0 except the limit, which reads all ones in the low CNT_W bits. Control words read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| obs_valid | input | 1 | A grant happened this cycle |
| obs_client | input | 6 | Winning client ID |
| obs_write | input | 1 | Granted request is a write |
| obs_hp | input | 1 | High-priority signal of the grant |
| obs_tm | input | 1 | Timeout signal of the grant |
| obs_bw | input | 1 | Bandwidth signal of the grant |
| obs_page_miss | input | 1 | Grant caused a page miss |
| obs_auto_pre | input | 1 | Grant carries auto-precharge |
| obs_bank_aa | input | 1 | Bank-AA arbitration flag |
| obs_bank_bb | input | 1 | Bank-BB arbitration flag |

## Verification
The bench builds the block with CNT_W = 16 and REG_W = 32. The narrower counters make the all-ones limit a 16-bit value, which the reset readback checks, while the register bus still carries full 32-bit control words. A limit of 5 is written to bring saturation within a few cycles, so the bench can confirm that the clock count and both event counts freeze on the same edge. Directed grant sequences, each opened by a clear command, give exact expected counts for every event class and filter mode.

// File: rtl/arbstat_pkg.sv
package arbstat_pkg;

    localparam int NUM_GATHER = 2;
    localparam int CID_W      = 6;

    // command field of the command register
    localparam int CMD_LSB = 8;
    typedef enum logic [1:0] {
        CMD_RESET   = 2'd0,
        CMD_CLEAR   = 2'd1,
        CMD_DISABLE = 2'd2,
        CMD_ENABLE  = 2'd3
    } gather_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD,
        ST_SAT
    } gather_state_e;

    // control word field positions
    localparam int CID_LSB   = 8;
    localparam int EVT_LSB   = 16;
    localparam int PSEL_LSB  = 24;
    localparam int CFEN_BIT  = 26;
    localparam int PMODE_LSB = 28;

    // event classes
    localparam logic [7:0] EV_QUAL    = 8'd0;
    localparam logic [7:0] EV_READ    = 8'd1;
    localparam logic [7:0] EV_WRITE   = 8'd2;
    localparam logic [7:0] EV_RWCHG   = 8'd3;
    localparam logic [7:0] EV_SUCC    = 8'd4;
    localparam logic [7:0] EV_BANK_AA = 8'd5;
    localparam logic [7:0] EV_BANK_BB = 8'd6;
    localparam logic [7:0] EV_PMISS   = 8'd7;
    localparam logic [7:0] EV_AUTOPRE = 8'd8;

    typedef struct packed {
        logic [CID_W-1:0] client;
        logic [7:0]       evsel;
        logic [1:0]       psel;
        logic             cfen;
        logic [1:0]       pmode;
    } gather_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [CID_W-1:0] client;
        logic             write;
        logic             hp;
        logic             tm;
        logic             bw;
        logic             page_miss;
        logic             auto_pre;
        logic             bank_aa;
        logic             bank_bb;
    } grant_obs_t;

    // register word addresses
    localparam int A_CMD    = 0;
    localparam int A_LIMIT  = 1;
    localparam int A_CFG0   = 2;
    localparam int A_CLOCKS = 4;
    localparam int A_CNT0   = 5;

endpackage

// File: rtl/arbstat_ctrl.sv
module arbstat_ctrl
    import arbstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  gather_cmd_e          cmd,
    input  logic [CNT_W-1:0]     limit,
    output gather_state_e        state,
    output logic [CNT_W-1:0]     clk_cnt,
    output logic                 count_en,
    output logic                 clr
);

    gather_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   tick_sum;

    assign tick_sum = {1'b0, cnt_q} + 1'b1;

    // counter next value
    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (state_q == ST_RUN)
            cnt_d = tick_sum[CNT_W-1:0];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_wr) begin
            unique case (cmd)
                CMD_RESET, CMD_CLEAR: state_d = ST_IDLE;
                CMD_DISABLE:          state_d = ST_HOLD;
                CMD_ENABLE:           state_d = (cnt_d >= limit) ? ST_SAT : ST_RUN;
            endcase
        end else begin
            unique case (state_q)
                ST_RUN:  if (cnt_d >= limit) state_d = ST_SAT;
                ST_IDLE, ST_HOLD, ST_SAT: state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        clr      = cmd_wr && (cmd == CMD_RESET || cmd == CMD_CLEAR);
        count_en = (state_q == ST_RUN);
        state    = state_q;
        clk_cnt  = cnt_q;
    end

    AST_RUN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !clr) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
    AST_CLEAR_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && state_q == ST_IDLE)); // R9
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cmd_wr) |=> $stable(cnt_q)); // R8
    AST_SAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAT && !cmd_wr) |=> ($stable(cnt_q) && state_q == ST_SAT)); // R10

endmodule

// File: rtl/arbstat_history.sv
module arbstat_history
    import arbstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  grant_obs_t obs,
    output logic       succ_hit,
    output logic       rwchg_hit
);

    logic             prev_vld;
    logic [CID_W-1:0] prev_client;
    logic             prev_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_vld    <= 1'b0;
            prev_client <= '0;
            prev_write  <= 1'b0;
        end else if (clr) begin
            prev_vld    <= 1'b0;
            prev_client <= '0;
            prev_write  <= 1'b0;
        end else if (upd && obs.valid) begin
            prev_vld    <= 1'b1;
            prev_client <= obs.client;
            prev_write  <= obs.write;
        end
    end

    always_comb begin
        succ_hit  = obs.valid && prev_vld && (obs.client == prev_client);
        rwchg_hit = obs.valid && prev_vld && (obs.write != prev_write);
    end

    AST_HIST_FORGET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !prev_vld); // R9

endmodule

// File: rtl/arbstat_event.sv
module arbstat_event
    import arbstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             count_en,
    input  gather_cfg_t      cfg,
    input  grant_obs_t       obs,
    input  logic             succ_hit,
    input  logic             rwchg_hit,
    output logic [CNT_W-1:0] cnt
);

    logic base_hit, psig, pri_ok, cid_ok, hit;

    always_comb begin
        case (cfg.evsel)
            EV_QUAL:    base_hit = obs.valid;
            EV_READ:    base_hit = obs.valid && !obs.write;
            EV_WRITE:   base_hit = obs.valid && obs.write;
            EV_RWCHG:   base_hit = rwchg_hit;
            EV_SUCC:    base_hit = succ_hit;
            EV_BANK_AA: base_hit = obs.valid && obs.bank_aa;
            EV_BANK_BB: base_hit = obs.valid && obs.bank_bb;
            EV_PMISS:   base_hit = obs.valid && obs.page_miss;
            EV_AUTOPRE: base_hit = obs.valid && obs.auto_pre;
            default:    base_hit = 1'b0;
        endcase

        case (cfg.psel)
            2'd0:    psig = obs.hp;
            2'd1:    psig = obs.tm;
            2'd2:    psig = obs.bw;
            default: psig = 1'b0;
        endcase

        case (cfg.pmode)
            2'd0:    pri_ok = 1'b1;
            2'd1:    pri_ok = !psig;
            2'd2:    pri_ok = psig;
            default: pri_ok = 1'b0;
        endcase

        cid_ok = !cfg.cfen || (obs.client == cfg.client);
        hit    = base_hit && pri_ok && cid_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (count_en && hit)
            cnt <= cnt + 1'b1;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clr) |=> $stable(cnt)); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0); // R9
    AST_NO_GRANT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!obs.valid && !clr) |=> $stable(cnt)); // R7

endmodule

// File: rtl/arb_stat_gatherer.sv
module arb_stat_gatherer
    import arbstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int REG_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              obs_valid,
    input  logic [5:0]        obs_client,
    input  logic              obs_write,
    input  logic              obs_hp,
    input  logic              obs_tm,
    input  logic              obs_bw,
    input  logic              obs_page_miss,
    input  logic              obs_auto_pre,
    input  logic              obs_bank_aa,
    input  logic              obs_bank_bb
);

    localparam int LIM_W = (CNT_W < REG_W) ? CNT_W : REG_W;

    logic [1:0]       cmd_q;
    logic [CNT_W-1:0] limit_q;
    logic [REG_W-1:0] cfg_q [NUM_GATHER];
    logic [CNT_W-1:0] ev_cnt [NUM_GATHER];
    logic [CNT_W-1:0] clk_cnt;
    gather_state_e    state;
    logic             cmd_wr, count_en, clr, succ_hit, rwchg_hit;
    grant_obs_t       obs;

    assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(A_CMD));

    assign obs = '{valid: obs_valid, client: obs_client, write: obs_write,
                   hp: obs_hp, tm: obs_tm, bw: obs_bw, page_miss: obs_page_miss,
                   auto_pre: obs_auto_pre, bank_aa: obs_bank_aa, bank_bb: obs_bank_bb};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= 2'd0;
            limit_q <= '1;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_CMD))
                cmd_q <= reg_wdata[CMD_LSB+1:CMD_LSB];
            if (reg_addr == ADDR_W'(A_LIMIT))
                limit_q <= CNT_W'(reg_wdata[LIM_W-1:0]);
        end
    end

    arbstat_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd      (gather_cmd_e'(reg_wdata[CMD_LSB+1:CMD_LSB])),
        .limit    (limit_q),
        .state    (state),
        .clk_cnt  (clk_cnt),
        .count_en (count_en),
        .clr      (clr)
    );

    arbstat_history u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .upd       (count_en),
        .obs       (obs),
        .succ_hit  (succ_hit),
        .rwchg_hit (rwchg_hit)
    );

    for (genvar g = 0; g < NUM_GATHER; g++) begin : g_gather
        gather_cfg_t cfg;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (reg_wr && reg_addr == ADDR_W'(A_CFG0 + g))
                cfg_q[g] <= reg_wdata;
        end

        assign cfg = '{client: cfg_q[g][CID_LSB +: CID_W],
                       evsel:  cfg_q[g][EVT_LSB +: 8],
                       psel:   cfg_q[g][PSEL_LSB +: 2],
                       cfen:   cfg_q[g][CFEN_BIT],
                       pmode:  cfg_q[g][PMODE_LSB +: 2]};

        arbstat_event #(.CNT_W(CNT_W)) u_event (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .count_en  (count_en),
            .cfg       (cfg),
            .obs       (obs),
            .succ_hit  (succ_hit),
            .rwchg_hit (rwchg_hit),
            .cnt       (ev_cnt[g])
        );

        AST_FREEZE_WITH_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_SAT && !cmd_wr) |=> $stable(ev_cnt[g])); // R10
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CMD))
            reg_rdata = REG_W'({cmd_q, 8'd0});
        else if (reg_addr == ADDR_W'(A_LIMIT))
            reg_rdata = REG_W'(limit_q);
        else if (reg_addr == ADDR_W'(A_CLOCKS))
            reg_rdata = REG_W'(clk_cnt);
        for (int g = 0; g < NUM_GATHER; g++) begin
            if (reg_addr == ADDR_W'(A_CFG0 + g))
                reg_rdata = cfg_q[g];
            if (reg_addr == ADDR_W'(A_CNT0 + g))
                reg_rdata = REG_W'(ev_cnt[g]);
        end
    end

endmodule

// File: tb/test_arb_stat_gatherer.sv
module test_arb_stat_gatherer;

    localparam int CW = 16;
    localparam logic [2:0] A_CMD = 0, A_LIM = 1, A_C0 = 2, A_C1 = 3, A_CLK = 4, A_N0 = 5, A_N1 = 6;
    localparam int F_HP = 1, F_TM = 2, F_BW = 4, F_PM = 8, F_AP = 16, F_AA = 32, F_BB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        obs_valid = 1'b0, obs_write = 1'b0, obs_hp = 1'b0, obs_tm = 1'b0, obs_bw = 1'b0;
    logic        obs_page_miss = 1'b0, obs_auto_pre = 1'b0, obs_bank_aa = 1'b0, obs_bank_bb = 1'b0;
    logic [5:0]  obs_client = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    arb_stat_gatherer #(.CNT_W(CW), .REG_W(32), .ADDR_W(3)) i_arb_stat_gatherer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .obs_valid(obs_valid),
        .obs_client(obs_client), .obs_write(obs_write), .obs_hp(obs_hp),
        .obs_tm(obs_tm), .obs_bw(obs_bw), .obs_page_miss(obs_page_miss),
        .obs_auto_pre(obs_auto_pre), .obs_bank_aa(obs_bank_aa), .obs_bank_bb(obs_bank_bb)
    );

    task automatic check(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] got;
        reg_addr = a;
        #1;
        got = reg_rdata;
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s addr %0d: actual %0h expected %0h", req, a, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cmd(input int c);
        wr(A_CMD, 32'(c) << 8);
    endtask

    task automatic grant(input int cl, input bit w, input int f);
        obs_valid = 1'b1; obs_client = 6'(cl); obs_write = w;
        obs_hp = f[0]; obs_tm = f[1]; obs_bw = f[2]; obs_page_miss = f[3];
        obs_auto_pre = f[4]; obs_bank_aa = f[5]; obs_bank_bb = f[6];
        @(posedge clk);
        @(negedge clk);
        obs_valid = 1'b0; obs_hp = 0; obs_tm = 0; obs_bw = 0; obs_page_miss = 0;
        obs_auto_pre = 0; obs_bank_aa = 0; obs_bank_bb = 0;
    endtask

    task automatic idle(input int n, input int f);
        for (int i = 0; i < n; i++) begin
            obs_page_miss = f[3]; obs_bank_aa = f[5];
            @(posedge clk);
            @(negedge clk);
        end
        obs_page_miss = 0; obs_bank_aa = 0;
    endtask

    task automatic start(input logic [31:0] c0, input logic [31:0] c1);
        wr(A_C0, c0);
        wr(A_C1, c1);
        cmd(1);
        cmd(3);
    endtask

    task automatic t_reset_state;
        check("R11 cmd", A_CMD, 0);
        check("R11 limit", A_LIM, 32'h0000FFFF);
        check("R11 clocks", A_CLK, 0);
        check("R11 cnt0", A_N0, 0);
        check("R11 cnt1", A_N1, 0);
        check("R11 cfg0", A_C0, 0);
    endtask

    task automatic t_read_write;
        start(32'd1 << 16, 32'd2 << 16);
        grant(1, 0, 0); grant(2, 1, 0); grant(3, 0, 0); grant(4, 1, 0); grant(5, 0, 0);
        idle(2, 0);
        cmd(2);
        check("R2 reads", A_N0, 3);
        check("R2 writes", A_N1, 2);
        check("R1 clocks", A_CLK, 8);
        check("R11 cfg readback", A_C1, 32'h00020000);
        check("R11 cmd readback", A_CMD, 32'h200);
    endtask

    task automatic t_disable_hold;
        grant(1, 0, 0); grant(1, 0, 0); grant(1, 1, 0);
        check("R8 held cnt0", A_N0, 3);
        check("R8 held cnt1", A_N1, 2);
        check("R8 held clocks", A_CLK, 8);
        cmd(3);
        grant(1, 0, 0); grant(1, 0, 0);
        cmd(2);
        check("R8 resumed clocks", A_CLK, 11);
        check("R8 resumed cnt0", A_N0, 5);
    endtask

    task automatic t_client_filter;
        start((32'd5 << 8) | (32'd1 << 26), 32'd0);
        grant(5, 0, 0); grant(3, 1, 0); grant(5, 1, 0); grant(7, 0, 0);
        cmd(2);
        check("R3 filtered", A_N0, 2);
        check("R3 unfiltered", A_N1, 4);
    endtask

    task automatic t_priority;
        start((32'd1 << 24) | (32'd2 << 28), (32'd0 << 24) | (32'd1 << 28));
        grant(1, 0, F_TM | F_HP); grant(1, 0, F_TM); grant(1, 0, 0);
        grant(1, 0, F_HP); grant(1, 0, F_BW);
        cmd(2);
        check("R4 timeout high", A_N0, 2);
        check("R4 hp low", A_N1, 3);
        start((32'd2 << 24) | (32'd2 << 28), 32'd3 << 28);
        grant(1, 0, F_BW); grant(1, 0, F_HP); grant(1, 0, F_BW | F_TM);
        cmd(2);
        check("R4 bw high", A_N0, 2);
        check("R4 mode3 none", A_N1, 0);
    endtask

    task automatic t_succ_rw;
        start(32'd4 << 16, 32'd3 << 16);
        grant(2, 0, 0); grant(2, 0, 0); grant(2, 1, 0); grant(9, 1, 0); grant(9, 0, 0);
        idle(1, 0);
        grant(9, 0, 0);
        cmd(2);
        check("R5 successive", A_N0, 4);
        check("R6 rw change", A_N1, 2);
    endtask

    task automatic t_flags;
        start(32'd7 << 16, 32'd8 << 16);
        grant(1, 0, F_PM); grant(2, 0, F_PM | F_AP); grant(3, 1, F_AP); grant(4, 0, 0);
        idle(1, F_PM);
        cmd(2);
        check("R7 page miss", A_N0, 2);
        check("R7 auto precharge", A_N1, 2);
        start(32'd5 << 16, 32'd6 << 16);
        grant(1, 0, F_AA); grant(1, 0, F_AA | F_BB); grant(1, 0, F_BB); grant(1, 0, F_BB);
        idle(1, F_AA);
        cmd(2);
        check("R7 bank aa", A_N0, 2);
        check("R7 bank bb", A_N1, 3);
        start(32'd9 << 16, 32'd200 << 16);
        grant(1, 0, 127); grant(1, 1, 127);
        cmd(2);
        check("R7 undefined sel 9", A_N0, 0);
        check("R7 undefined sel 200", A_N1, 0);
    endtask

    task automatic t_clear_history;
        start(32'd4 << 16, 32'd0);
        grant(4, 0, 0); grant(4, 0, 0);
        check("R5 running succ", A_N0, 1);
        cmd(1);
        check("R9 clear clocks", A_CLK, 0);
        check("R9 clear cnt1", A_N1, 0);
        cmd(3);
        grant(4, 0, 0);
        cmd(2);
        check("R9 history forgotten", A_N0, 0);
        check("R9 first grant counted", A_N1, 1);
        cmd(0);
        check("R9 reset cmd clocks", A_CLK, 0);
        check("R9 reset cmd cnt1", A_N1, 0);
    endtask

    task automatic t_limit;
        wr(A_LIM, 32'd5);
        start(32'd0, 32'd1 << 16);
        for (int i = 0; i < 8; i++) grant(i, 0, 0);
        check("R10 clocks at limit", A_CLK, 5);
        check("R10 cnt0 frozen", A_N0, 5);
        check("R10 cnt1 frozen", A_N1, 5);
        cmd(2);
        check("R10 still at limit", A_CLK, 5);
        wr(A_LIM, 32'hFFFFFFFF);
        check("R10 max limit", A_LIM, 32'h0000FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_read_write();
        t_disable_hold();
        t_client_filter();
        t_priority();
        t_succ_rw();
        t_flags();
        t_clear_history();
        t_limit();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule